// File: doc/BRIEF.md
# Enhanced Parallel Port Host Cycle Engine

This block runs address and data cycles on an enhanced parallel port from the host side. Internal logic sends one cycle at a time over a valid/ready request channel. Each request carries three things: whether the cycle targets the address or the data channel, whether it reads or writes, and the byte to write. The block sets up the port, asserts the matching strobe and holds it for as long as the peripheral asks through its wait line. It then releases the strobe and returns a response. The response holds the byte read from the port and a flag that marks a timeout.

On the port side the block drives a byte-wide shared bus with a separate output enable. It also drives four active-low outputs: a write indication, a data strobe, an address strobe and a peripheral reset. It samples the peripheral's active-low wait line and an interrupt line, each through a two-flop synchronizer. A cycle that gets no acknowledge within a limit set at run time ends on its own and sets a sticky timeout flag. The host clears that flag with a one-clock pulse. A limit of 1024 clocks is the usual setting.

Back-pressure rules: `req_ready` is high only while the engine is idle. A request transfers on a clock edge where `req_valid` and `req_ready` are both high. `rsp_valid` stays high, with `rsp_rdata` and `rsp_timeout` unchanged, until a clock edge where `rsp_ready` is high. No new request is accepted before then.

Top module: `epp_cycle_ctrl`

## Requirements
- R1: After reset: `n_write`, `n_dstb`, `n_astb` and `n_rst` are 1; `pd_oe`, `rsp_valid`, `tmo_flag`, `intr_out` and `intr_rise` are 0; `req_ready` is 1.
- R2: `req_ready` is high only when idle. It falls on the edge that accepts a request and rises again on the edge after the response is taken.
- R3: On a write (`req_is_read`=0), the edge that accepts the request sets `pd_oe`=1, `n_write`=0 and `pd_out` to the request byte. These values hold unchanged while the strobe is low.
- R4: On a read (`req_is_read`=1), the accepting edge sets `n_write`=1 and `pd_oe`=0 before any strobe falls. `rsp_rdata` returns `pd_in` as sampled on the edge that ends the cycle. A write returns `rsp_rdata`=0.
- R5: `req_is_addr`=1 selects `n_astb` and `req_is_addr`=0 selects `n_dstb`. The selected strobe falls on the second edge after acceptance. The other strobe stays high, and the two are never low together.
- R6: While the synchronized `n_wait` is low, the strobe stays low. If `n_wait` rises after the k-th clock of strobe-low, the strobe is low for exactly k+2 clocks.
- R7: The strobe stays low for at least two clocks. With `n_wait` already high when the strobe falls, it is low for exactly two clocks.
- R8: With no acknowledge, the strobe is low for exactly `tmo_limit` clocks (for `tmo_limit` of 2 or more). The cycle then ends with `rsp_timeout`=1. If an acknowledge and the limit fall on the same edge, the acknowledge wins.
- R9: A timeout sets `tmo_flag`, which stays set until a clock edge with `tmo_clr`=1 and no new timeout. A timeout on the same edge keeps the flag set.
- R10: `rsp_valid` rises on the edge that releases the strobe. Its payload then holds steady until taken, and both strobes stay high for at least that one clock.
- R11: `intr_out` follows `intr_in` two edges later, without inversion. `intr_rise` is high for exactly one clock when `intr_out` rises.
- R12: `n_rst` is the inverse of `port_rst`, registered one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Cycle request valid |
| req_ready | output | 1 | Engine idle, can take a request |
| req_is_addr | input | 1 | 1 = address cycle, 0 = data cycle |
| req_is_read | input | 1 | 1 = read, 0 = write |
| req_wdata | input | DATA_W | Byte to write |
| rsp_valid | output | 1 | Cycle response valid |
| rsp_ready | input | 1 | Response taken |
| rsp_rdata | output | DATA_W | Byte read from the port |
| rsp_timeout | output | 1 | Cycle ended by timeout |
| tmo_limit | input | TMO_W | Strobe-low clock limit |
| tmo_flag | output | 1 | Sticky timeout status |
| tmo_clr | input | 1 | Clears the sticky flag |
| port_rst | input | 1 | Requests peripheral reset |
| pd_out | output | DATA_W | Port bus output value |
| pd_oe | output | 1 | Port bus output enable |
| pd_in | input | DATA_W | Port bus input value |
| n_write | output | 1 | Active-low write indication |
| n_dstb | output | 1 | Active-low data strobe |
| n_astb | output | 1 | Active-low address strobe |
| n_rst | output | 1 | Active-low peripheral reset |
| n_wait | input | 1 | Active-low peripheral wait |
| intr_in | input | 1 | Peripheral interrupt |
| intr_out | output | 1 | Synchronized interrupt level |
| intr_rise | output | 1 | One-clock rising-edge pulse |

## Verification
The port setup is due one edge after acceptance, and the strobe falls one edge after that. An acknowledge is seen two edges after `n_wait` rises, and the strobe is released, together with `rsp_valid`, on the third. A timeout comes exactly `tmo_limit` strobe clocks after the fall. The interrupt path has a latency of two edges and the reset output has a latency of one. The bench drives and samples 2 ns after each rising edge. It counts the strobe-low samples of each cycle, compares that count with the exact figure the requirement gives for the chosen acknowledge delay, and checks each result in the sample where it is due.

// File: rtl/epp_pkg.sv
package epp_pkg;
  localparam int EPP_DATA_W = 8;
  localparam int EPP_TMO_W  = 16;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_SETUP   = 2'd1,
    ST_STROBE  = 2'd2,
    ST_RECOVER = 2'd3
  } epp_state_e;
endpackage

// File: rtl/epp_sync.sv
module epp_sync #(
  parameter int              WIDTH   = 1,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[s] <= RST_VAL;
        else        chain_q[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[s] <= RST_VAL;
        else        chain_q[s] <= chain_q[s-1];
      end
    end
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/epp_wait_timer.sv
module epp_wait_timer #(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [TMO_W-1:0] limit,
  output logic             min_ok,
  output logic             expire
);
  localparam int CW = TMO_W + 1;

  logic [TMO_W-1:0] cnt_q;
  logic [CW-1:0]    elapsed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (!run)           cnt_q <= '0;
    else if (cnt_q != '1)    cnt_q <= cnt_q + 1'b1;
  end

  assign elapsed = {1'b0, cnt_q} + CW'(1);
  assign min_ok  = run && (cnt_q != '0);
  assign expire  = min_ok && (elapsed >= {1'b0, limit});

  AST_EXPIRE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> !run); // R8
endmodule

// File: rtl/epp_cycle_fsm.sv
module epp_cycle_fsm
  import epp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_is_addr,
  input  logic              req_is_read,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_timeout,
  input  logic              wait_hi,
  input  logic              min_ok,
  input  logic              expire,
  output logic              strobe_run,
  output logic              tmo_hit,
  output logic [DATA_W-1:0] pd_out,
  output logic              pd_oe,
  input  logic [DATA_W-1:0] pd_in,
  output logic              n_write,
  output logic              n_dstb,
  output logic              n_astb
);
  epp_state_e state_q;
  logic       cyc_addr_q;
  logic       cyc_read_q;
  logic       ack_ok;
  logic       finish;
  logic       stb_act;

  assign ack_ok     = wait_hi && min_ok;
  assign finish     = (state_q == ST_STROBE) && (ack_ok || expire);
  assign tmo_hit    = finish && !ack_ok;
  assign strobe_run = (state_q == ST_STROBE);
  assign req_ready  = (state_q == ST_IDLE);
  assign stb_act    = !n_astb || !n_dstb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      cyc_addr_q  <= 1'b0;
      cyc_read_q  <= 1'b0;
      pd_out      <= '0;
      pd_oe       <= 1'b0;
      n_write     <= 1'b1;
      n_dstb      <= 1'b1;
      n_astb      <= 1'b1;
      rsp_valid   <= 1'b0;
      rsp_rdata   <= '0;
      rsp_timeout <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            cyc_addr_q <= req_is_addr;
            cyc_read_q <= req_is_read;
            n_write    <= req_is_read;
            pd_oe      <= !req_is_read;
            if (!req_is_read) pd_out <= req_wdata;
            state_q    <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          if (cyc_addr_q) n_astb <= 1'b0;
          else            n_dstb <= 1'b0;
          state_q <= ST_STROBE;
        end
        ST_STROBE: begin
          if (finish) begin
            n_astb      <= 1'b1;
            n_dstb      <= 1'b1;
            rsp_valid   <= 1'b1;
            rsp_timeout <= !ack_ok;
            rsp_rdata   <= cyc_read_q ? pd_in : '0;
            state_q     <= ST_RECOVER;
          end
        end
        ST_RECOVER: begin
          if (rsp_ready) begin
            rsp_valid <= 1'b0;
            state_q   <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(!n_astb && !n_dstb)); // R5
  AST_MIN_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stb_act) |=> stb_act); // R7
  AST_DIR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    stb_act |-> ($stable(n_write) && $stable(pd_oe) && $stable(pd_out))); // R3
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_timeout))); // R10
  AST_BUSY_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_act || rsp_valid) |-> !req_ready); // R2
endmodule

// File: rtl/epp_cycle_ctrl.sv
module epp_cycle_ctrl
  import epp_pkg::*;
#(
  parameter int DATA_W      = EPP_DATA_W,
  parameter int TMO_W       = EPP_TMO_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_is_addr,
  input  logic              req_is_read,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_timeout,
  input  logic [TMO_W-1:0]  tmo_limit,
  output logic              tmo_flag,
  input  logic              tmo_clr,
  input  logic              port_rst,
  output logic [DATA_W-1:0] pd_out,
  output logic              pd_oe,
  input  logic [DATA_W-1:0] pd_in,
  output logic              n_write,
  output logic              n_dstb,
  output logic              n_astb,
  output logic              n_rst,
  input  logic              n_wait,
  input  logic              intr_in,
  output logic              intr_out,
  output logic              intr_rise
);
  localparam int SYNC_W = 2;

  logic [SYNC_W-1:0] sync_d;
  logic [SYNC_W-1:0] sync_q;
  logic              wait_hi;
  logic              intr_prev_q;
  logic              strobe_run;
  logic              min_ok;
  logic              expire;
  logic              tmo_hit;

  assign sync_d = {intr_in, n_wait};

  epp_sync #(
    .WIDTH  (SYNC_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL('0)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (sync_d),
    .q    (sync_q)
  );

  assign wait_hi  = sync_q[0];
  assign intr_out = sync_q[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) intr_prev_q <= 1'b0;
    else        intr_prev_q <= intr_out;
  end

  assign intr_rise = intr_out && !intr_prev_q;

  epp_wait_timer #(
    .TMO_W(TMO_W)
  ) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (strobe_run),
    .limit (tmo_limit),
    .min_ok(min_ok),
    .expire(expire)
  );

  epp_cycle_fsm #(
    .DATA_W(DATA_W)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_is_addr(req_is_addr),
    .req_is_read(req_is_read),
    .req_wdata  (req_wdata),
    .rsp_valid  (rsp_valid),
    .rsp_ready  (rsp_ready),
    .rsp_rdata  (rsp_rdata),
    .rsp_timeout(rsp_timeout),
    .wait_hi    (wait_hi),
    .min_ok     (min_ok),
    .expire     (expire),
    .strobe_run (strobe_run),
    .tmo_hit    (tmo_hit),
    .pd_out     (pd_out),
    .pd_oe      (pd_oe),
    .pd_in      (pd_in),
    .n_write    (n_write),
    .n_dstb     (n_dstb),
    .n_astb     (n_astb)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tmo_flag <= 1'b0;
    else if (tmo_hit) tmo_flag <= 1'b1;
    else if (tmo_clr) tmo_flag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) n_rst <= 1'b1;
    else        n_rst <= !port_rst;
  end

  AST_TMO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_flag && !tmo_clr) |=> tmo_flag); // R9
  AST_TMO_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_timeout && !$past(rsp_valid)) |-> tmo_flag); // R8
  AST_INTR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    intr_rise |=> !intr_rise); // R11
endmodule

// File: tb/epp_cycle_ctrl_tb.sv
`timescale 1ns/1ps
module epp_cycle_ctrl_tb;
  localparam int DW = 8;
  localparam int TW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_is_addr = 1'b0;
  logic          req_is_read = 1'b0;
  logic [DW-1:0] req_wdata = '0;
  logic          rsp_valid;
  logic          rsp_ready = 1'b1;
  logic [DW-1:0] rsp_rdata;
  logic          rsp_timeout;
  logic [TW-1:0] tmo_limit = 16'd1024;
  logic          tmo_flag;
  logic          tmo_clr = 1'b0;
  logic          port_rst = 1'b0;
  logic [DW-1:0] pd_out;
  logic          pd_oe;
  logic [DW-1:0] pd_in = '0;
  logic          n_write;
  logic          n_dstb;
  logic          n_astb;
  logic          n_rst;
  logic          n_wait = 1'b0;
  logic          intr_in = 1'b0;
  logic          intr_out;
  logic          intr_rise;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  epp_cycle_ctrl #(.DATA_W(DW), .TMO_W(TW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_is_addr(req_is_addr),
    .req_is_read(req_is_read), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .rsp_timeout(rsp_timeout), .tmo_limit(tmo_limit), .tmo_flag(tmo_flag),
    .tmo_clr(tmo_clr), .port_rst(port_rst), .pd_out(pd_out), .pd_oe(pd_oe),
    .pd_in(pd_in), .n_write(n_write), .n_dstb(n_dstb), .n_astb(n_astb),
    .n_rst(n_rst), .n_wait(n_wait), .intr_in(intr_in), .intr_out(intr_out),
    .intr_rise(intr_rise)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  // One port cycle; dly 0: wait high before strobe, k>0: raise after k-th low clock, -1: never
  task automatic run_cycle(input bit a, input bit rd, input logic [DW-1:0] wb,
                           input logic [DW-1:0] rb, input int dly, input int hold,
                           input bit exp_tmo, input int exp_low);
    int low;
    logic [DW-1:0] held;
    low = 0;
    n_wait    = (dly == 0);
    pd_in     = (dly == 0) ? rb : 8'h00;
    rsp_ready = (hold == 0);
    chk(req_ready == 1'b1, "R2 ready when idle", int'(req_ready), 1);
    req_valid = 1'b1; req_is_addr = a; req_is_read = rd; req_wdata = wb;
    tick();
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R2 busy after accept", int'(req_ready), 0);
    chk(n_write == rd, "R3 R4 nwrite in setup", int'(n_write), int'(rd));
    chk(pd_oe == !rd, "R3 R4 oe in setup", int'(pd_oe), int'(!rd));
    chk(n_astb && n_dstb, "R5 no strobe in setup", int'({n_astb, n_dstb}), 3);
    if (!rd) chk(pd_out == wb, "R3 write byte", int'(pd_out), int'(wb));
    while (!rsp_valid && low < 5000) begin
      tick();
      if (!rsp_valid) begin
        low++;
        if (low == 1) begin
          chk(n_astb == !a && n_dstb == a, "R5 strobe select",
              int'({n_astb, n_dstb}), int'({!a, a}));
          chk(n_write == rd && pd_oe == !rd, "R3 R4 dir at strobe",
              int'({n_write, pd_oe}), int'({rd, !rd}));
        end
        if (dly > 0 && low == dly) begin
          n_wait = 1'b1;
          pd_in  = rb;
        end
      end
    end
    chk(low == exp_low, "R6 R7 R8 strobe low clocks", low, exp_low);
    chk(n_astb && n_dstb, "R10 strobes released", int'({n_astb, n_dstb}), 3);
    chk(rsp_timeout == exp_tmo, "R8 timeout status", int'(rsp_timeout), int'(exp_tmo));
    if (rd && !exp_tmo) chk(rsp_rdata == rb, "R4 read byte", int'(rsp_rdata), int'(rb));
    if (!rd) chk(rsp_rdata == 8'h00, "R4 write returns zero", int'(rsp_rdata), 0);
    chk(req_ready == 1'b0, "R10 no accept while response pending", int'(req_ready), 0);
    n_wait = 1'b0;
    held = rsp_rdata;
    for (int i = 0; i < hold; i++) begin
      tick();
      chk(rsp_valid && rsp_rdata == held && n_astb && n_dstb, "R10 response held",
          int'(rsp_rdata), int'(held));
    end
    rsp_ready = 1'b1;
    tick();
    chk(!rsp_valid && req_ready, "R2 idle after response", int'({rsp_valid, req_ready}), 1);
  endtask

  task automatic test_reset();
    chk(n_write && n_dstb && n_astb && n_rst, "R1 outputs high",
        int'({n_write, n_dstb, n_astb, n_rst}), 15);
    chk(!pd_oe && !rsp_valid && !tmo_flag && !intr_out && !intr_rise, "R1 outputs low",
        int'({pd_oe, rsp_valid, tmo_flag, intr_out, intr_rise}), 0);
    chk(req_ready == 1'b1, "R1 ready", int'(req_ready), 1);
  endtask

  task automatic test_write_data();
    run_cycle(1'b0, 1'b0, 8'hA5, 8'h00, 0, 0, 1'b0, 2); // R7
    chk(tmo_flag == 1'b0, "R9 no flag on acked cycle", int'(tmo_flag), 0);
  endtask

  task automatic test_write_addr();
    run_cycle(1'b1, 1'b0, 8'h3C, 8'h00, 3, 0, 1'b0, 5); // R6
  endtask

  task automatic test_read_data();
    run_cycle(1'b0, 1'b1, 8'h00, 8'h5E, 5, 0, 1'b0, 7); // R4 R6
  endtask

  task automatic test_read_addr();
    run_cycle(1'b1, 1'b1, 8'h00, 8'hC3, 0, 0, 1'b0, 2); // R4 R7
  endtask

  task automatic test_backpressure();
    run_cycle(1'b0, 1'b1, 8'h00, 8'h96, 1, 3, 1'b0, 3); // R10
  endtask

  task automatic test_timeout();
    tmo_limit = 16'd20;
    run_cycle(1'b0, 1'b1, 8'h00, 8'h00, -1, 0, 1'b1, 20); // R8
    chk(tmo_flag == 1'b1, "R9 flag set", int'(tmo_flag), 1);
    run_cycle(1'b1, 1'b0, 8'h11, 8'h00, 2, 0, 1'b0, 4);
    chk(tmo_flag == 1'b1, "R9 flag sticky", int'(tmo_flag), 1);
    tmo_clr = 1'b1;
    tick();
    tmo_clr = 1'b0;
    chk(tmo_flag == 1'b0, "R9 flag cleared", int'(tmo_flag), 0);
    tmo_limit = 16'd1024;
  endtask

  task automatic test_intr();
    intr_in = 1'b1;
    tick();
    chk(intr_out == 1'b0, "R11 one edge", int'(intr_out), 0);
    tick();
    chk(intr_out && intr_rise, "R11 two edges", int'({intr_out, intr_rise}), 3);
    tick();
    chk(intr_out && !intr_rise, "R11 single pulse", int'({intr_out, intr_rise}), 2);
    intr_in = 1'b0;
    tick();
    tick();
    chk(!intr_out && !intr_rise, "R11 falls", int'({intr_out, intr_rise}), 0);
  endtask

  task automatic test_port_reset();
    port_rst = 1'b1;
    tick();
    chk(n_rst == 1'b0, "R12 asserted", int'(n_rst), 0);
    port_rst = 1'b0;
    tick();
    chk(n_rst == 1'b1, "R12 released", int'(n_rst), 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    test_reset();
    rst_n = 1'b1;
    tick();
    test_reset();
    test_write_data();
    test_write_addr();
    test_read_data();
    test_read_addr();
    test_backpressure();
    test_timeout();
    test_intr();
    test_port_reset();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule